// File: doc/BRIEF.md
# Cascaded Trapezoidal Pulse Shaper

This block reshapes a stream of signed samples taken from a detector whose pulses rise fast and decay exponentially. Each input pulse comes out as a symmetric trapezoid: a linear ramp over `na` samples, a flat top that ends at sample `nb`, and a linear ramp back to zero that ends at sample `na + nb`. When `nb` equals `na` the flat top vanishes and the result is a triangle. The height of the flat top is proportional to the pulse amplitude, which makes it the quantity that later logic measures.

The filter is built as four registered stages in a row. The first stage subtracts from each sample the sample `na` clocks older. The second is a recursive integrator that weights the current and the previous input with two signed fractional coefficients. Software computes these coefficients from the decay constant so that the decay pole is cancelled. The third stage is a plain running sum. The fourth subtracts from the running sum its own value `nb` clocks older. All internal arithmetic is exact fixed point and the result is rounded once, at the end. The lengths and coefficients are captured only while the block is held in reset. In a typical system two copies run side by side, one set up for a trapezoid and one for a triangle.

Top module: `trap_shaper`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the edge clears every stage, both delay lines and the output, whatever `sample_in` carries, so `shaped_out` reads 0.
- R2: With `coef_cur = c`, `coef_old = -c` and a step of height A that starts at sample index 0, the output for index n is round(c·A·(clamp(n+1,0,na) − clamp(n+1−nb,0,na)) / 2^30). The output therefore ramps for na samples, holds until index nb−1 and is zero from index na+nb−1 on.
- R3: A sample applied at clock edge t first affects `shaped_out` after edge t+4. Output index n is visible after edge t0+n+4.
- R4: For any input, the output is the rounded value of the exact product (1 − z^-na)·(c_cur + c_old·z^-1)/(1 − z^-1)·1/(1 − z^-1)·(1 − z^-nb) applied to the input. The coefficients are signed with 30 fractional bits, and all arithmetic is 52 bits wide with 30 fractional bits, with no truncation before the final step.
- R5: For an exponential pulse A·d^n, with `coef_cur` = round(2^30/na) and `coef_old` = −round(2^30·d/na), the flat top lies within ±3 of A, and the output is within ±3 of zero once the trapezoid has ended.
- R6: With nb = na, the output is a triangle whose single peak, at index na−1, equals round(c·A·na/2^30).
- R7: `shaped_out` is the 18-bit signed value of bits 47..30 of the final 52-bit value plus bit 29, which rounds half up: 62.5 gives 63 and −62.5 gives −62.
- R8: `rise_len`, `top_end`, `coef_cur` and `coef_old` are sampled only at edges where `rst_n` is low. Changes to them while `rst_n` is high have no effect on the output.
- R9: The lengths must satisfy 1 ≤ na ≤ nb ≤ DEPTH (default 400), and nb = DEPTH is fully supported.
- R10: Two pulses that start at least na+nb samples apart produce two separate trapezoids, each with its own flat-top height.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| rise_len | input | SEL_W (9) | Ramp length na in samples |
| top_end | input | SEL_W (9) | Sample index nb at which the flat top ends |
| coef_cur | input | COEF_W (32) | Signed weight of the current integrator input, 30 fractional bits |
| coef_old | input | COEF_W (32) | Signed weight of the previous integrator input, 30 fractional bits |
| sample_in | input | SAMPLE_W (15) | Signed two's complement detector sample, one per clock |
| shaped_out | output | OUT_W (18) | Signed rounded shaped sample, one per clock |

## Verification
The hardest condition to reach is a true cancellation of the decay pole. The ideal exponential arrives as rounded integers, and the coefficients are rounded too, so a flat plateau and a clean return to zero only appear when the stimulus and the coefficients come from the same decay constant. The bench computes both from one real-valued decay factor. It then compares every output sample against an exact integer model that applies the two differences before the integrators. Because that arithmetic is exact, this differently ordered model must match bit for bit. The tests that exercise the 400-deep delay line and the frozen configuration use long steps, and the ports are changed halfway through a pulse.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int SAMPLE_W_DEF = 15;
    localparam int COEF_W_DEF   = 32;
    localparam int ACC_W_DEF    = 52;
    localparam int FRAC_W_DEF   = 30;
    localparam int OUT_MSB_DEF  = 47;
    localparam int DEPTH_DEF    = 400;
endpackage

// File: rtl/trap_delay_diff.sv
module trap_delay_diff #(
    parameter int W     = 15,
    parameter int OW    = 16,
    parameter int DEPTH = 400,
    parameter int SEL_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     sel,
    input  logic signed [W-1:0]  din,
    output logic signed [OW-1:0] dout
);
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] hist;
        logic [OW-1:0]           diff;
    } state_t;

    state_t st_d, st_q;
    logic signed [W-1:0]  tap;
    logic signed [OW-1:0] din_x, tap_x;

    always_comb begin
        if (sel == '0) tap = din;
        else           tap = st_q.hist[sel - 1'b1];
    end

    generate
        if (OW > W) begin : g_widen
            assign din_x = {{(OW-W){din[W-1]}}, din};
            assign tap_x = {{(OW-W){tap[W-1]}}, tap};
        end else begin : g_same
            assign din_x = din;
            assign tap_x = tap;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.hist = {st_q.hist[DEPTH-2:0], din};
        st_d.diff = din_x - tap_x;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.diff;

    // R9: selected delay must lie inside the line
    p_sel_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != '0) && (sel <= SEL_MAX));
endmodule

// File: rtl/trap_scaled_integ.sv
module trap_scaled_integ #(
    parameter int IN_W   = 16,
    parameter int COEF_W = 32,
    parameter int ACC_W  = 52
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [COEF_W-1:0] coef_now,
    input  logic signed [COEF_W-1:0] coef_prev,
    input  logic signed [IN_W-1:0]   din,
    output logic signed [ACC_W-1:0]  dout
);
    localparam int PROD_W = IN_W + COEF_W;

    typedef struct packed {
        logic [IN_W-1:0]  prev;
        logic [ACC_W-1:0] acc;
    } state_t;

    state_t st_d, st_q;
    logic signed [IN_W-1:0]   prev_s;
    logic signed [PROD_W-1:0] p_now, p_old;
    logic signed [ACC_W-1:0]  e_now, e_old;

    assign prev_s = st_q.prev;
    assign p_now  = din * coef_now;
    assign p_old  = prev_s * coef_prev;
    assign e_now  = {{(ACC_W-PROD_W){p_now[PROD_W-1]}}, p_now};
    assign e_old  = {{(ACC_W-PROD_W){p_old[PROD_W-1]}}, p_old};

    always_comb begin
        st_d      = st_q;
        st_d.prev = din;
        st_d.acc  = st_q.acc + e_now + e_old;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.acc;

    // R4: with no input in the window the integrator keeps its value
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (din == '0) && (prev_s == '0) |=> $stable(dout));
endmodule

// File: rtl/trap_accum.sv
module trap_accum #(
    parameter int ACC_W = 52
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] dout
);
    typedef struct packed {
        logic [ACC_W-1:0] sum;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sum = st_q.sum + din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.sum;

    // R4: a zero input leaves the running sum unchanged
    p_sum_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (din == '0) |=> $stable(dout));
endmodule

// File: rtl/trap_shaper.sv
module trap_shaper #(
    parameter int SAMPLE_W = trap_pkg::SAMPLE_W_DEF,
    parameter int COEF_W   = trap_pkg::COEF_W_DEF,
    parameter int ACC_W    = trap_pkg::ACC_W_DEF,
    parameter int FRAC_W   = trap_pkg::FRAC_W_DEF,
    parameter int OUT_MSB  = trap_pkg::OUT_MSB_DEF,
    parameter int DEPTH    = trap_pkg::DEPTH_DEF,
    localparam int SEL_W   = $clog2(DEPTH + 1),
    localparam int OUT_W   = OUT_MSB - FRAC_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         rise_len,
    input  logic [SEL_W-1:0]         top_end,
    input  logic signed [COEF_W-1:0] coef_cur,
    input  logic signed [COEF_W-1:0] coef_old,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    output logic signed [OUT_W-1:0]  shaped_out
);
    localparam int DIFF_W = SAMPLE_W + 1;

    typedef struct packed {
        logic [SEL_W-1:0]  rise;
        logic [SEL_W-1:0]  tlen;
        logic [COEF_W-1:0] ca;
        logic [COEF_W-1:0] cb;
        logic [OUT_W-1:0]  out;
    } state_t;

    state_t st_d, st_q;
    logic signed [DIFF_W-1:0] d1;
    logic signed [ACC_W-1:0]  y2, y3, y4;
    logic [OUT_W-1:0]         rounded;

    trap_delay_diff #(
        .W(SAMPLE_W), .OW(DIFF_W), .DEPTH(DEPTH), .SEL_W(SEL_W)
    ) u_head_diff (
        .clk(clk), .rst_n(rst_n), .sel(st_q.rise), .din(sample_in), .dout(d1)
    );

    trap_scaled_integ #(
        .IN_W(DIFF_W), .COEF_W(COEF_W), .ACC_W(ACC_W)
    ) u_pole_integ (
        .clk(clk), .rst_n(rst_n),
        .coef_now(signed'(st_q.ca)), .coef_prev(signed'(st_q.cb)),
        .din(d1), .dout(y2)
    );

    trap_accum #(
        .ACC_W(ACC_W)
    ) u_ramp_sum (
        .clk(clk), .rst_n(rst_n), .din(y2), .dout(y3)
    );

    trap_delay_diff #(
        .W(ACC_W), .OW(ACC_W), .DEPTH(DEPTH), .SEL_W(SEL_W)
    ) u_tail_diff (
        .clk(clk), .rst_n(rst_n), .sel(st_q.tlen), .din(y3), .dout(y4)
    );

    assign rounded = y4[OUT_MSB:FRAC_W] + {{(OUT_W-1){1'b0}}, y4[FRAC_W-1]};

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.rise = rise_len;
            st_d.tlen = top_end;
            st_d.ca   = coef_cur;
            st_d.cb   = coef_old;
            st_d.out  = '0;
        end else begin
            st_d.out  = rounded;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign shaped_out = st_q.out;

    // R1: a reset edge leaves the output at zero
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (shaped_out == '0));

    // R8: configuration does not move while running
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(st_q.rise) && $stable(st_q.tlen)
                  && $stable(st_q.ca) && $stable(st_q.cb));

    // R9: ramp length never exceeds the flat-top end
    p_len_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rise <= st_q.tlen);
endmodule

// File: tb/trap_shaper_tb.sv
`timescale 1ns/1ps
module trap_shaper_tb;
    localparam int SELW = 9;
    localparam longint ONE = 64'sd1 << 30;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                rst_n;
    logic [SELW-1:0]     rise_len, top_end;
    logic signed [31:0]  coef_cur, coef_old;
    logic signed [14:0]  sample_in;
    logic signed [17:0]  shaped_out;

    trap_shaper u_dut (
        .clk(clk), .rst_n(rst_n), .rise_len(rise_len), .top_end(top_end),
        .coef_cur(coef_cur), .coef_old(coef_old),
        .sample_in(sample_in), .shaped_out(shaped_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    longint xin  [0:1023];
    longint expv [0:1023];
    longint got  [0:1023];

    function automatic longint rnd(longint s);
        return (s >>> 30) + ((s >>> 29) & 64'sd1);
    endfunction

    function automatic longint clampi(longint v, longint lo, longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic longint xa(int k);
        if (k < 0) return 0;
        return xin[k];
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_near(string req, longint act, longint exp, longint tol);
        checks++;
        if (act > exp + tol || act < exp - tol) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d +/- %0d", req, act, exp, tol);
        end
    endtask

    // closed form for a step of height amp (R2, R6)
    task automatic fill_step(longint amp, int na, int nb, longint c, int len);
        for (int i = 0; i < len; i++) begin
            xin[i]  = amp;
            expv[i] = rnd(c * amp * (clampi(i + 1, 0, na) - clampi(i + 1 - nb, 0, na)));
        end
    endtask

    // exact model with both differences applied before the integrators (R4)
    task automatic fill_model(int na, int nb, longint c1, longint c0, int len);
        longint w = 0, s = 0, up = 0, u;
        for (int n = 0; n < len; n++) begin
            u  = xa(n) - xa(n - na) - xa(n - nb) + xa(n - na - nb);
            w  = w + c1 * u + c0 * up;
            up = u;
            s  = s + w;
            expv[n] = rnd(s);
        end
    endtask

    task automatic apply_reset(int na, int nb, longint c1, longint c0);
        @(negedge clk);
        rst_n     = 1'b0;
        sample_in = '0;
        rise_len  = SELW'(na);
        top_end   = SELW'(nb);
        coef_cur  = 32'(c1);
        coef_old  = 32'(c0);
        repeat (3) @(negedge clk);
        check("R1 output during reset", longint'(shaped_out), 0);
    endtask

    // Output index n is visible after edge t0+n+4 (R3)
    task automatic run_stream(string req, int len, bit poke);
        for (int i = 0; i <= len + 4; i++) begin
            int idx = i - 5;
            if (idx >= 0) begin
                got[idx] = longint'(shaped_out);
                check(req, got[idx], expv[idx]);
            end else begin
                check(req, longint'(shaped_out), 0);
            end
            rst_n     = 1'b1;
            sample_in = (i < len) ? xin[i][14:0] : 15'sd0;
            if (poke && i == len / 2) begin
                rise_len = 9'd5;
                top_end  = 9'd7;
                coef_cur = 32'sd0;
                coef_old = 32'sd12345;
            end
            @(negedge clk);
        end
        sample_in = '0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        sample_in = 15'sd12345;
        rise_len  = 9'd16;
        top_end   = 9'd40;
        coef_cur  = 32'(ONE / 16);
        coef_old  = -32'(ONE / 16);
        repeat (4) @(negedge clk);
        check("R1 reset with active input", longint'(shaped_out), 0);
    endtask

    task automatic test_step();
        fill_step(1000, 16, 40, ONE / 16, 70);
        apply_reset(16, 40, ONE / 16, -(ONE / 16));
        run_stream("R2 R3 step trapezoid", 70, 1'b0);
        check("R7 half-up positive first sample", got[0], 63);
        check("R2 flat top", got[30], 1000);
        check("R2 back to zero at na+nb-1", got[55], 0);
    endtask

    task automatic test_triangle();
        longint c = (ONE + 12) / 24;
        fill_step(3000, 24, 24, c, 60);
        apply_reset(24, 24, c, -c);
        run_stream("R6 triangle", 60, 1'b0);
        check("R6 triangle peak", got[23], rnd(c * 3000 * 24));
    endtask

    task automatic test_negative();
        fill_step(-1000, 16, 20, ONE / 16, 50);
        apply_reset(16, 20, ONE / 16, -(ONE / 16));
        run_stream("R7 negative step", 50, 1'b0);
        check("R7 half-up negative first sample", got[0], -62);
    endtask

    task automatic test_exp();
        real d = $exp(-1.0 / 50.0);
        longint c1 = longint'($rtoi(1073741824.0 / 20.0 + 0.5));
        longint c0 = -longint'($rtoi(1073741824.0 * d / 20.0 + 0.5));
        for (int n = 0; n < 140; n++) xin[n] = longint'($rtoi(8000.0 * (d ** n) + 0.5));
        fill_model(20, 50, c1, c0, 140);
        apply_reset(20, 50, c1, c0);
        run_stream("R4 exponential pulse model", 140, 1'b0);
        for (int n = 20; n < 50; n++) check_near("R5 plateau height", got[n], 8000, 3);
        for (int n = 72; n < 140; n++) check_near("R5 return to baseline", got[n], 0, 3);
    endtask

    task automatic test_two_pulses();
        real d = $exp(-1.0 / 50.0);
        longint c1 = longint'($rtoi(1073741824.0 / 20.0 + 0.5));
        longint c0 = -longint'($rtoi(1073741824.0 * d / 20.0 + 0.5));
        for (int n = 0; n < 180; n++) begin
            xin[n] = longint'($rtoi(6000.0 * (d ** n) + 0.5));
            if (n >= 80) xin[n] += longint'($rtoi(4000.0 * (d ** (n - 80)) + 0.5));
        end
        fill_model(20, 50, c1, c0, 180);
        apply_reset(20, 50, c1, c0);
        run_stream("R10 R4 two pulses", 180, 1'b0);
        for (int n = 20; n < 50; n++)   check_near("R10 first plateau", got[n], 6000, 3);
        for (int n = 100; n < 130; n++) check_near("R10 second plateau", got[n], 4000, 3);
    endtask

    task automatic test_cfg_frozen();
        fill_step(2000, 16, 40, ONE / 16, 70);
        apply_reset(16, 40, ONE / 16, -(ONE / 16));
        run_stream("R8 config change while running ignored", 70, 1'b1);
    endtask

    task automatic test_max_depth();
        fill_step(500, 8, 400, ONE / 8, 420);
        apply_reset(8, 400, ONE / 8, -(ONE / 8));
        run_stream("R9 flat top at full depth", 420, 1'b0);
        check("R9 last flat-top sample", got[399], 500);
        check("R9 falls to zero", got[407], 0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (R1..all): actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        sample_in = '0;
        rise_len  = 9'd16;
        top_end   = 9'd40;
        coef_cur  = '0;
        coef_old  = '0;
        test_reset();
        test_step();
        test_triangle();
        test_negative();
        test_exp();
        test_two_pulses();
        test_cfg_frozen();
        test_max_depth();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule